// File: doc/BRIEF.md
# Copy-Control and Aspect-Ratio Line Data Serializer

This block turns two small data words into a timed serial bit stream for a video encoder. One word is a 20-bit copy-generation control word (14 payload bits plus a 6-bit check code) used with 525-line (NTSC) output. The other is a 14-bit wide-screen signalling word used with 625-line (PAL) output. The block watches a line-start strobe, with the current line number, field parity and standard. On a line that may carry data it samples the data inputs and emits one bit per cell of a fixed number of pixel clocks.

The copy-control word goes out on line 20 of the odd field and on line 283 of the even field. Each field has its own enable. The word starts with a two-cell reference preamble. Its check code is either computed by the block from the 14 payload bits or taken unchanged from the input word. The wide-screen word goes out on line 23, and only when the standard is PAL. The block produces only the digital bit value and its timing. Shaping, filtering and mixing into luma are done downstream.

Top module: `vbi_word_serializer`

## Requirements
- R1: After reset, `ser_bit`, `insert_active` and `bit_strobe` are all 0 until an eligible line start is seen.
- R2: With `std_pal`=0, a `line_start` pulse on line 20 with `field_odd`=1 and `cgms_odd_en`=1 starts a copy-control frame. So does a pulse on line 283 with `field_odd`=0 and `cgms_even_en`=1. Each field's enable has no effect on the other field's line.
- R3: A copy-control frame is 22 cells: the preamble bit 1, then the preamble bit 0, then word bits C0 to C19, lowest bit first.
- R4: With `crc_auto`=1, bit C(14+i) sent equals bit i of a 6-bit register `c`. `c` is preset to 6'b111111 and updated for each payload bit d = C0 to C13 in turn: fb = c[5] xor d, then c = {c[4:0],0} xor (fb ? 6'b000011 : 0). This is the polynomial x^6+x+1.
- R5: With `crc_auto`=0, the sent bits C14 to C19 equal `cgms_word[19:14]` unchanged.
- R6: With `std_pal`=1 and `wss_en`=1, a `line_start` on line 23 starts a wide-screen frame of 14 cells carrying `wss_word[0]` to `wss_word[13]` in that order, with no preamble.
- R7: No frame starts on a line start that is not eligible. This covers a wide-screen request while `std_pal`=0, a copy-control request while `std_pal`=1, disabled enables, and any other line number.
- R8: Every copy-control cell lasts CGMS_CELL clocks and every wide-screen cell lasts WSS_CELL clocks. `bit_strobe` is high on the first clock of each cell. `insert_active` is high for exactly (cells × cell length) clocks, starting the clock after the `line_start` pulse. `ser_bit` is constant within a cell.
- R9: The data and control inputs are sampled only at the accepted line start. A change to `cgms_word` during a frame does not alter the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-clock pulse at the start of each line |
| line_num | input | LINE_W | Current line number, valid with `line_start` |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| std_pal | input | 1 | 1 for PAL output, 0 for NTSC output |
| cgms_odd_en | input | 1 | Copy-control enable for the odd field |
| cgms_even_en | input | 1 | Copy-control enable for the even field |
| wss_en | input | 1 | Wide-screen enable |
| crc_auto | input | 1 | 1 computes check bits internally, 0 passes them through |
| cgms_word | input | 20 | Copy-control word C19..C0 |
| wss_word | input | 14 | Wide-screen word |
| ser_bit | output | 1 | Current serial bit value |
| insert_active | output | 1 | High while a frame is being sent |
| bit_strobe | output | 1 | High on the first clock of each bit cell |

## Verification
The bench compares every emitted bit against a check code computed from random payloads, with internal generation both on and off. A wrong preset, a wrong tap or a reversed order would corrupt the last six cells. It sends requests that must be ignored: a wide-screen request in NTSC, a copy-control request in PAL, the wrong field for an enable, and lines next to the target lines. A design that decodes the standard or parity loosely would start a frame there. It also changes the copy-control word in the middle of a frame, which exposes a design that reads its input live instead of taking a snapshot. It counts active clocks per frame, so a cell counter that is off by one shows up as a length mismatch.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
   localparam int CG_PAYLOAD = 14;
   localparam int CG_CHECK   = 6;
   localparam int CG_BITS    = CG_PAYLOAD + CG_CHECK;
   localparam int PRE_BITS   = 2;
   localparam int CG_FRAME   = CG_BITS + PRE_BITS;
   localparam int WS_BITS    = 14;
   localparam logic [PRE_BITS-1:0] PRE_PATTERN = 2'b01;
   localparam logic [CG_CHECK-1:0] CRC_SEED    = '1;
   localparam logic [CG_CHECK-1:0] CRC_TAPS    = 6'b000011;
endpackage

// File: rtl/vbi_crc6.sv
module vbi_crc6
   import vbi_pkg::*;
(
   input  logic                crc_auto,
   input  logic [CG_BITS-1:0]  word_in,
   output logic [CG_BITS-1:0]  word_out
);
   logic [CG_CHECK-1:0] stage [CG_PAYLOAD+1];

   assign stage[0] = CRC_SEED;

   for (genvar g = 0; g < CG_PAYLOAD; g++) begin : g_step
      logic fb;
      assign fb = stage[g][CG_CHECK-1] ^ word_in[g];
      assign stage[g+1] = {stage[g][CG_CHECK-2:1], stage[g][0] ^ fb, fb};
   end

   always_comb begin
      word_out = word_in;
      if (crc_auto)
         word_out[CG_BITS-1:CG_PAYLOAD] = stage[CG_PAYLOAD];
   end
endmodule

// File: rtl/vbi_line_gate.sv
module vbi_line_gate #(
   parameter int LINE_W     = 10,
   parameter int LINE_ODD   = 20,
   parameter int LINE_EVEN  = 283,
   parameter int LINE_WIDE  = 23
) (
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic              field_odd,
   input  logic              std_pal,
   input  logic              cgms_odd_en,
   input  logic              cgms_even_en,
   input  logic              wss_en,
   output logic              go_cg,
   output logic              go_ws
);
   localparam logic [LINE_W-1:0] L_ODD  = LINE_W'(LINE_ODD);
   localparam logic [LINE_W-1:0] L_EVEN = LINE_W'(LINE_EVEN);
   localparam logic [LINE_W-1:0] L_WIDE = LINE_W'(LINE_WIDE);

   if (LINE_EVEN >= (1 << LINE_W)) begin : g_bad_width
      $error("line number width too small for target lines");
   end

   logic odd_hit, even_hit;
   assign odd_hit  = field_odd  && cgms_odd_en  && (line_num == L_ODD);
   assign even_hit = !field_odd && cgms_even_en && (line_num == L_EVEN);
   assign go_cg = line_start && !std_pal && (odd_hit || even_hit);
   assign go_ws = line_start && std_pal && wss_en && (line_num == L_WIDE);
endmodule

// File: rtl/vbi_bit_shifter.sv
module vbi_bit_shifter #(
   parameter int FRAME_W = 22,
   parameter int NBITS_A = 22,
   parameter int NBITS_B = 14,
   parameter int CELL_A  = 4,
   parameter int CELL_B  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_a,
   input  logic               go_b,
   input  logic [FRAME_W-1:0] word_a,
   input  logic [FRAME_W-1:0] word_b,
   output logic               ser_bit,
   output logic               active,
   output logic               strobe
);
   localparam int CMAX  = (CELL_A > CELL_B) ? CELL_A : CELL_B;
   localparam int CNT_W = $clog2(CMAX + 1);
   localparam int IDX_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] A_LAST = CNT_W'(CELL_A - 1);
   localparam logic [CNT_W-1:0] B_LAST = CNT_W'(CELL_B - 1);
   localparam logic [IDX_W-1:0] A_END  = IDX_W'(NBITS_A - 1);
   localparam logic [IDX_W-1:0] B_END  = IDX_W'(NBITS_B - 1);

   if (CELL_A < 1 || CELL_B < 1) begin : g_bad_cell
      $error("bit cell length must be at least one clock");
   end
   if (NBITS_A > FRAME_W || NBITS_B > FRAME_W) begin : g_bad_frame
      $error("frame longer than shift register");
   end

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cell_cnt, cell_last;
   logic [IDX_W-1:0]   idx, idx_last;
   logic               start;

   assign start = (go_a || go_b) && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh        <= '0;
         cell_cnt  <= '0;
         cell_last <= '0;
         idx       <= '0;
         idx_last  <= '0;
         active    <= 1'b0;
      end else if (start) begin
         sh        <= go_a ? word_a : word_b;
         cell_last <= go_a ? A_LAST : B_LAST;
         idx_last  <= go_a ? A_END  : B_END;
         cell_cnt  <= '0;
         idx       <= '0;
         active    <= 1'b1;
      end else if (active) begin
         if (cell_cnt == cell_last) begin
            cell_cnt <= '0;
            sh       <= sh >> 1;
            if (idx == idx_last) active <= 1'b0;
            else                 idx    <= idx + 1'b1;
         end else begin
            cell_cnt <= cell_cnt + 1'b1;
         end
      end
   end

   assign ser_bit = active && sh[0];
   assign strobe  = active && (cell_cnt == '0);

   // R8
   first_cell_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> strobe);
   // R8
   cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !strobe) |-> $stable(ser_bit));
   // R8
   cell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cell_cnt <= cell_last));
   // R7
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !go_a && !go_b) |=> !active);
endmodule

// File: rtl/vbi_word_serializer.sv
module vbi_word_serializer
   import vbi_pkg::*;
#(
   parameter int LINE_W    = 10,
   parameter int LINE_ODD  = 20,
   parameter int LINE_EVEN = 283,
   parameter int LINE_WIDE = 23,
   parameter int CGMS_CELL = 4,
   parameter int WSS_CELL  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic              field_odd,
   input  logic              std_pal,
   input  logic              cgms_odd_en,
   input  logic              cgms_even_en,
   input  logic              wss_en,
   input  logic              crc_auto,
   input  logic [19:0]       cgms_word,
   input  logic [13:0]       wss_word,
   output logic              ser_bit,
   output logic              insert_active,
   output logic              bit_strobe
);
   logic               go_cg, go_ws;
   logic [CG_BITS-1:0] cg_full;
   logic [CG_FRAME-1:0] frame_a, frame_b;

   vbi_line_gate #(
      .LINE_W(LINE_W), .LINE_ODD(LINE_ODD),
      .LINE_EVEN(LINE_EVEN), .LINE_WIDE(LINE_WIDE)
   ) u_gate (
      .line_start(line_start), .line_num(line_num), .field_odd(field_odd),
      .std_pal(std_pal), .cgms_odd_en(cgms_odd_en),
      .cgms_even_en(cgms_even_en), .wss_en(wss_en),
      .go_cg(go_cg), .go_ws(go_ws)
   );

   vbi_crc6 u_crc (
      .crc_auto(crc_auto), .word_in(cgms_word), .word_out(cg_full)
   );

   assign frame_a = {cg_full, PRE_PATTERN};
   assign frame_b = {{(CG_FRAME - WS_BITS){1'b0}}, wss_word};

   vbi_bit_shifter #(
      .FRAME_W(CG_FRAME), .NBITS_A(CG_FRAME), .NBITS_B(WS_BITS),
      .CELL_A(CGMS_CELL), .CELL_B(WSS_CELL)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .go_a(go_cg), .go_b(go_ws),
      .word_a(frame_a), .word_b(frame_b),
      .ser_bit(ser_bit), .active(insert_active), .strobe(bit_strobe)
   );

   // R2
   start_follows_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(insert_active) |-> $past(line_start));
   // R1
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insert_active |-> (!ser_bit && !bit_strobe));
endmodule

// File: tb/sim_vbi_word_serializer.sv
module sim_vbi_word_serializer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_start = 1'b0;
   logic [9:0] line_num = '0;
   logic field_odd = 1'b0, std_pal = 1'b0;
   logic cgms_odd_en = 1'b0, cgms_even_en = 1'b0, wss_en = 1'b0, crc_auto = 1'b0;
   logic [19:0] cgms_word = '0;
   logic [13:0] wss_word = '0;
   logic ser_bit, insert_active, bit_strobe;

   int checks = 0, fails = 0, act_cnt = 0, cycles = 0;
   bit exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   vbi_word_serializer u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
      .field_odd(field_odd), .std_pal(std_pal), .cgms_odd_en(cgms_odd_en),
      .cgms_even_en(cgms_even_en), .wss_en(wss_en), .crc_auto(crc_auto),
      .cgms_word(cgms_word), .wss_word(wss_word), .ser_bit(ser_bit),
      .insert_active(insert_active), .bit_strobe(bit_strobe)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] ref_crc(logic [13:0] d);
      logic [5:0] c = 6'b111111;
      for (int i = 0; i < 14; i++) begin
         logic fb = c[5] ^ d[i];
         c = {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b0);
      end
      return c;
   endfunction

   // R3 R4 R5: expected frame of a copy-control word
   task automatic push_cg(logic [19:0] w, bit auto_on);
      logic [19:0] full = w;
      string t = auto_on ? "R4" : "R5";
      if (auto_on) full[19:14] = ref_crc(w[13:0]);
      exp_q.push_back(1'b1); tag_q.push_back("R3");
      exp_q.push_back(1'b0); tag_q.push_back("R3");
      for (int i = 0; i < 20; i++) begin
         exp_q.push_back(full[i]);
         tag_q.push_back(i < 14 ? "R3" : t);
      end
   endtask

   task automatic push_ws(logic [13:0] w);
      for (int i = 0; i < 14; i++) begin
         exp_q.push_back(w[i]); tag_q.push_back("R6");
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (insert_active) act_cnt++;
         if (bit_strobe) begin
            if (exp_q.size() == 0) begin
               check("R7 unexpected bit", 1, 0);
            end else begin
               string t = tag_q.pop_front();
               check(t, int'(ser_bit), int'(exp_q.pop_front()));
            end
         end
      end
   end

   task automatic run_line(int ln, bit odd, int exp_active, string tag, int mid_wait = -1);
      @(negedge clk);
      act_cnt = 0;
      line_num = 10'(ln); field_odd = odd; line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      if (mid_wait >= 0) begin
         repeat (mid_wait) @(negedge clk);
         cgms_word = ~cgms_word;
         crc_auto = ~crc_auto;
      end
      repeat (120) @(negedge clk);
      check({tag, " active clocks"}, act_cnt, exp_active);
      check({tag, " leftover items"}, exp_q.size(), 0);
      exp_q.delete(); tag_q.delete();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ser_bit", int'(ser_bit), 0);
      check("R1 insert_active", int'(insert_active), 0);
      check("R1 bit_strobe", int'(bit_strobe), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle after reset", int'(insert_active | bit_strobe | ser_bit), 0);

      // R2 R3 R4 R5 R8: odd field, random payloads, check code on and off
      std_pal = 1'b0; cgms_odd_en = 1'b1; cgms_even_en = 1'b0;
      for (int k = 0; k < 12; k++) begin
         cgms_word = 20'($urandom);
         crc_auto = k[0];
         push_cg(cgms_word, crc_auto);
         run_line(20, 1'b1, 22*4, "R8 cgms odd");
      end
      // R2: even-field enable off, even line ignored
      run_line(283, 1'b0, 0, "R2 even disabled");
      // R2: even field only
      cgms_odd_en = 1'b0; cgms_even_en = 1'b1;
      run_line(20, 1'b1, 0, "R2 odd disabled");
      for (int k = 0; k < 4; k++) begin
         cgms_word = 20'($urandom); crc_auto = 1'b1;
         push_cg(cgms_word, 1'b1);
         run_line(283, 1'b0, 22*4, "R2 cgms even");
      end
      // R4 corner: all-zero and all-one payloads
      cgms_word = 20'h00000; push_cg(cgms_word, 1'b1);
      run_line(283, 1'b0, 88, "R4 zero payload");
      cgms_word = 20'h03FFF; push_cg(cgms_word, 1'b1);
      run_line(283, 1'b0, 88, "R4 ones payload");
      // R7: wrong lines, wrong parity
      run_line(282, 1'b0, 0, "R7 line 282");
      run_line(283, 1'b1, 0, "R7 odd parity on 283");
      // R7: wide-screen in NTSC ignored
      wss_en = 1'b1; wss_word = 14'h2A5B;
      run_line(23, 1'b1, 0, "R7 wss in ntsc");
      // R6 R8: PAL wide-screen
      std_pal = 1'b1;
      for (int k = 0; k < 4; k++) begin
         wss_word = 14'($urandom);
         push_ws(wss_word);
         run_line(23, k[0], 14*6, "R6 wss pal");
      end
      run_line(22, 1'b1, 0, "R7 wss line 22");
      // R7: copy-control ignored in PAL
      cgms_odd_en = 1'b1; cgms_even_en = 1'b1;
      run_line(20, 1'b1, 0, "R7 cgms in pal");
      run_line(283, 1'b0, 0, "R7 cgms even in pal");
      // R9: inputs changed mid-frame
      std_pal = 1'b0; crc_auto = 1'b1; cgms_word = 20'hA5C3E;
      push_cg(cgms_word, 1'b1);
      run_line(20, 1'b1, 88, "R9 mid-frame change", 30);
      crc_auto = 1'b0; cgms_word = 20'h5A3C1;
      push_cg(cgms_word, 1'b0);
      run_line(20, 1'b1, 88, "R9 mid-frame change pass", 50);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule